// File: doc/BRIEF.md
# Run-Length Bitmask Unit

This block is a single-cycle combinational datapath for 64-bit words. It builds a run of ones, starting at bit 0, whose length is chosen at run time. It then applies that run to a source word in one of five ways.

- Three modes move the run up by a run-time shift amount and merge it into the source: OR (set), AND-NOT (clear) or XOR (invert).
- An extract mode shifts the source right and keeps only the bits under the run.
- A reverse-extract mode mirrors the source bit order first. It measures the shift from the top end of the word, so it returns a reversed field of the source.

It sits in an execution pipeline behind the operand read. The caller presents the source word, the shift operand, the run length, a zero-shift select and an operation code. The caller takes the result in the same cycle. Operand fetch and instruction-field decoding are done outside this block.

Top module: `bm_unit`

## Requirements
- R1: The effective shift amount is the low 6 bits of `shamt_i` (the operand modulo 64). Bits 63:6 of `shamt_i` have no effect on the result.
- R2: A run length L on `len_i` gives a mask whose bits below L are one and whose other bits are zero. L=0 gives an empty mask, and any L of 64 or more gives all ones. With a zero source and a zero shift, set mode outputs exactly this mask.
- R3: Operation code 0 (set) returns `src_i | (mask << s)`, where s is the effective shift.
- R4: Operation code 1 (clear) returns `src_i & ~(mask << s)`.
- R5: Operation code 2 (invert) returns `src_i ^ (mask << s)`.
- R6: Operation code 3 (extract) returns `mask & (src_i >> s)`. The shift is logical, so zeros enter from the top and nothing wraps around.
- R7: Operation code 4 (reverse-extract) returns `mask & (rev(src_i) >> (63 - s))`. Here rev(x) bit i equals x bit 63-i.
- R8: When `zsel_i` is 1 in reverse-extract mode, s is taken as 0 before the 63-minus adjustment, whatever `shamt_i` holds. In every other mode `zsel_i` has no effect.
- R9: Operation codes 5, 6 and 7 return zero.
- R10: The result depends only on the present inputs. It settles within the same cycle and holds no state from earlier operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 (XLEN) | Source word |
| shamt_i | input | 64 (XLEN) | Shift operand; only the low 6 bits are used |
| len_i | input | 7 (LEN_W) | Run length of the mask; 64 and above saturate |
| zsel_i | input | 1 | Forces a zero shift in reverse-extract mode |
| op_i | input | 3 | Operation code (0 set, 1 clear, 2 invert, 3 extract, 4 reverse-extract) |
| result_o | output | 64 (XLEN) | Result word |

## Verification
The case that is hardest to reach from the ports is where the run length, the shift and the word edge meet. This happens when length plus shift passes 64 in the merge modes, and when the mirrored shift reaches 63 in reverse-extract. Lengths drawn uniformly over 0 to 127 would rarely land on the values that sit exactly at those edges. So the stimulus draws the length from a set weighted toward 0, 1, 63, 64 and 127, and puts large random values in the upper shift bits. Directed vectors then cover full-word reversal (shift 63, length 64), a zero-select with a non-zero shift, and the three unused operation codes.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    BM_SET  = 3'd0,
    BM_CLR  = 3'd1,
    BM_INV  = 3'd2,
    BM_EXT  = 3'd3,
    BM_REXT = 3'd4
  } bm_op_e;
endpackage

// File: rtl/bm_mask_gen.sv
// Thermometer mask: bit i is set when the run length exceeds i.
module bm_mask_gen #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [XLEN-1:0]  mask_o
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign mask_o[i] = (len_i > LEN_W'(i));
  end
endmodule

// File: rtl/bm_bit_rev.sv
// Mirrors bit order of a word.
module bm_bit_rev #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] d_o
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign d_o[i] = d_i[XLEN-1-i];
  end
endmodule

// File: rtl/bm_shift_sel.sv
// Picks the shift distance: direct for normal modes, mirrored for reverse mode.
module bm_shift_sel #(
  parameter int XLEN = 64,
  parameter int SH_W = 6
) (
  input  logic [SH_W-1:0] amt_i,
  input  logic            rev_i,
  input  logic            zsel_i,
  output logic [SH_W-1:0] amt_o
);
  localparam logic [SH_W-1:0] TopIdx = SH_W'(XLEN - 1);
  logic [SH_W-1:0] base;

  always_comb begin
    base  = (zsel_i && rev_i) ? '0 : amt_i;
    amt_o = rev_i ? (TopIdx - base) : base;
  end
endmodule

// File: rtl/bm_unit.sv
module bm_unit #(
  parameter  int XLEN  = 64,
  localparam int SH_W  = $clog2(XLEN),
  localparam int LEN_W = SH_W + 1
) (
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  shamt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             zsel_i,
  input  logic [2:0]       op_i,
  output logic [XLEN-1:0]  result_o
);
  import bm_pkg::*;

  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] src_rev;
  logic [SH_W-1:0] amt;
  logic            rev_mode;
  logic [XLEN-1:0] placed;
  logic [XLEN-1:0] pulled;
  logic            unused_shamt_hi;

  // Upper shift-operand bits are deliberately ignored.
  assign unused_shamt_hi = ^shamt_i[XLEN-1:SH_W];
  assign rev_mode        = (op_i == BM_REXT);

  bm_mask_gen #(.XLEN(XLEN), .LEN_W(LEN_W)) u_mask (
    .len_i  (len_i),
    .mask_o (mask)
  );

  bm_bit_rev #(.XLEN(XLEN)) u_rev (
    .d_i (src_i),
    .d_o (src_rev)
  );

  bm_shift_sel #(.XLEN(XLEN), .SH_W(SH_W)) u_sel (
    .amt_i  (shamt_i[SH_W-1:0]),
    .rev_i  (rev_mode),
    .zsel_i (zsel_i),
    .amt_o  (amt)
  );

  always_comb begin
    placed = mask << amt;
    pulled = (rev_mode ? src_rev : src_i) >> amt;
    unique case (op_i)
      BM_SET:  result_o = src_i | placed;
      BM_CLR:  result_o = src_i & ~placed;
      BM_INV:  result_o = src_i ^ placed;
      BM_EXT,
      BM_REXT: result_o = mask & pulled;
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/bm_unit_chk.sv
module bm_unit_chk #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input logic [XLEN-1:0]  src_i,
  input logic [XLEN-1:0]  shamt_i,
  input logic [LEN_W-1:0] len_i,
  input logic             zsel_i,
  input logic [2:0]       op_i,
  input logic [XLEN-1:0]  result_o
);
  logic unused_chk;
  assign unused_chk = ^shamt_i;

  always_comb begin
    if (op_i == 3'd0)
      assert_set_keeps_src_R3: assert ((result_o & src_i) == src_i);
    if (op_i == 3'd1)
      assert_clr_no_new_ones_R4: assert ((result_o & ~src_i) == '0);
    if (op_i == 3'd2 && len_i == '0)
      assert_inv_empty_mask_R5: assert (result_o == src_i);
    if (op_i == 3'd3 && len_i < LEN_W'(XLEN))
      assert_ext_within_run_R6: assert ((result_o >> len_i) == '0);
    if (op_i == 3'd4 && zsel_i)
      assert_rext_zsel_one_bit_R8: assert ((result_o >> 1) == '0);
    if (op_i > 3'd4)
      assert_unused_op_zero_R9: assert (result_o == '0);
  end
endmodule

bind bm_unit bm_unit_chk #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (
  .src_i    (src_i),
  .shamt_i  (shamt_i),
  .len_i    (len_i),
  .zsel_i   (zsel_i),
  .op_i     (op_i),
  .result_o (result_o)
);

// File: tb/bm_unit_tb.sv
`timescale 1ns/1ps
module bm_unit_tb;
  localparam int XLEN = 64;
  localparam int LEN_W = 7;

  logic             clk;
  logic             rst_n;
  logic [XLEN-1:0]  src_i, shamt_i;
  logic [LEN_W-1:0] len_i;
  logic             zsel_i;
  logic [2:0]       op_i;
  logic [XLEN-1:0]  result_o;
  int               n_cmp, n_bad;
  bit               done;

  bm_unit u_dut (
    .src_i(src_i), .shamt_i(shamt_i), .len_i(len_i),
    .zsel_i(zsel_i), .op_i(op_i), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] sh,
                                        input int len, input bit z, input int op);
    logic [63:0] m, rv, p;
    int a;
    m = '0;
    for (int i = 0; i < 64; i++) m[i] = (i < len);
    for (int i = 0; i < 64; i++) rv[i] = s[63-i];
    a = int'(sh % 64);
    p = m << a;
    case (op)
      0: return s | p;
      1: return s & ~p;
      2: return s ^ p;
      3: return m & (s >> a);
      4: begin
           if (z) a = 0;
           return m & (rv >> (63 - a));
         end
      default: return 64'd0;
    endcase
  endfunction

  task automatic run(input logic [63:0] s, input logic [63:0] sh, input int len,
                     input bit z, input int op, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    src_i = s; shamt_i = sh; len_i = LEN_W'(len); zsel_i = z; op_i = 3'(op);
    exp = model(s, sh, len, z, op);
    #1;
    n_cmp++;
    if (result_o !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, op, result_o, exp);
    end
  endtask

  function automatic int pick_len();
    int r;
    r = int'($urandom % 8);
    case (r)
      0: return 0;
      1: return 1;
      2: return 63;
      3: return 64;
      4: return 127;
      default: return int'($urandom % 128);
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog expired got=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    src_i = '0; shamt_i = '0; len_i = '0; zsel_i = 1'b0; op_i = 3'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs: zero source, zero length in set mode
    run(64'h0, 64'h0, 0, 0, 0, "R2 reset-state zero");
    // R2: bare run with zero source and shift
    run(64'h0, 64'h0, 5, 0, 0, "R2 run of 5");
    run(64'h0, 64'h0, 64, 0, 0, "R2 len 64 all ones");
    run(64'h0, 64'h0, 127, 0, 0, "R2 len 127 saturates");
    run(64'h0, 64'h0, 63, 0, 0, "R2 len 63");
    // R1: upper shift bits ignored
    run(64'h0, 64'hFFFF_FFFF_FFFF_FFC4, 8, 0, 0, "R1 high bits ignored");
    run(64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0003, 16, 0, 3, "R1 ext high bits");
    // R3-R5 across the word edge
    run(64'h0F0F_0F0F_0F0F_0F0F, 64'd60, 10, 0, 0, "R3 set crosses top");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd60, 10, 0, 1, "R4 clear crosses top");
    run(64'hAAAA_AAAA_AAAA_AAAA, 64'd1, 64, 0, 2, "R5 invert full");
    // R6 logical shift, no wrap
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 64, 0, 3, "R6 ext no wrap");
    // R7 full reversal with shift 63
    run(64'h0123_4567_89AB_CDEF, 64'd63, 64, 0, 4, "R7 full reversal");
    run(64'h0123_4567_89AB_CDEF, 64'd7, 8, 0, 4, "R7 low byte reversed");
    // R8 zero select
    run(64'h0000_0000_0000_0001, 64'd40, 64, 1, 4, "R8 zsel forces zero");
    run(64'hFFFF_FFFF_FFFF_FFFE, 64'd40, 64, 1, 4, "R8 zsel bit0 clear");
    run(64'h5555_0000_1111_2222, 64'd12, 20, 1, 0, "R8 zsel no effect set");
    run(64'h5555_0000_1111_2222, 64'd12, 20, 1, 3, "R8 zsel no effect ext");
    // R9 unused codes
    run(64'hDEAD_BEEF_CAFE_F00D, 64'd3, 9, 0, 5, "R9 op5");
    run(64'hDEAD_BEEF_CAFE_F00D, 64'd3, 9, 1, 6, "R9 op6");
    run(64'hDEAD_BEEF_CAFE_F00D, 64'd3, 9, 0, 7, "R9 op7");

    // R10 plus all modes: random vectors back to back, no state carried
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s, sh;
      int op;
      s  = {$urandom, $urandom};
      sh = {$urandom, $urandom};
      op = int'($urandom % 8);
      case (op)
        0: run(s, sh, pick_len(), 1'($urandom), op, "R3 random");
        1: run(s, sh, pick_len(), 1'($urandom), op, "R4 random");
        2: run(s, sh, pick_len(), 1'($urandom), op, "R5 random");
        3: run(s, sh, pick_len(), 1'($urandom), op, "R6 random");
        4: run(s, sh, pick_len(), 1'($urandom), op, "R7 random");
        default: run(s, sh, pick_len(), 1'($urandom), op, "R10 random");
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule